// File: doc/BRIEF.md
# Data Translation Fault Checker and Latch

This block sits on the data side of address translation, after the translation lookup. Each request carries a virtual address, a read or write indication and the current privilege mode. It also carries request qualifiers: a page-table-entry load, a no-fault access, a write hint and a misspeculated access. The looked-up entry comes with the request: a hit bit, read and write enables for each mode, and fault-on-read and fault-on-write bits.

The block decides whether the access succeeds. If it does not, the block reports a single fault class and a status word. One cycle after the request it presents that outcome, together with the effective address. A write hint's effective address is rounded down to its 64-byte line.

Faults are also captured in three software-visible registers: the faulting address, the status word, and a formatted address built from a page-table base and the virtual page number. Capture is skipped for page-table-entry loads, no-fault accesses and misspeculated accesses. Reading the registers has no side effect. Four saturating counters tally read and write misses and read and write protection faults.

Top module: `dxf_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `rsp_valid`, `rsp_class`, `rsp_status`, `rsp_addr`, all three fault registers and all four counters read zero.
- R2: An address that is not canonical gives class 2 (protection). A canonical address has bits 63 down to 42 all equal. The status is access-violation (bit 1) plus bad-address (bit 4), plus write (bit 0) for a write.
- R3: A canonical address with bits 42:41 equal to `2'b10` is a superpage access. In any mode other than 0 it gives class 1 (access) with status access-violation, plus write for a write. In mode 0 it succeeds whatever the entry holds.
- R4: A lookup miss gives status miss (bit 5), plus write for a write. The class is 4 (table miss) for a page-table-entry load and 3 (miss) otherwise.
- R5: A write whose write enable for the current mode is clear gives class 2. The status is write plus access-violation, plus fault-on-write (bit 3) if the entry's fault-on-write bit is set.
- R6: A permitted write with fault-on-write set gives class 2 with status write plus fault-on-write.
- R7: A read whose read enable for the current mode is clear gives class 1. The status is access-violation, plus fault-on-read (bit 2) if the entry's fault-on-read bit is set.
- R8: A permitted read with fault-on-read set gives class 2 with status fault-on-read only. A write ignores fault-on-read. An access with no fault gives class 0 and status 0.
- R9: Only the first cause that applies is reported, in this order: non-canonical address, superpage mode, miss, permission, fault-on bits.
- R10: The fault registers load only on a faulting request that is not a page-table-entry load, not no-fault, not a write hint and not misspeculated. Otherwise they hold their values.
- R11: On load, the formatted register takes `pt_base` ORed with the address's page number (address bits 63:13) shifted left by 3.
- R12: A write hint is a write and a no-fault access. Its address bits 5:0 are cleared before any check, and `rsp_addr` shows the cleared address.
- R13: Each faulting request adds one to exactly one counter, which saturates at 255. Misses count by direction in the miss counters. Every other fault counts by direction in the protection counters.
- R14: `rsp_*` reflects the request sampled at the previous clock edge. `rsp_valid` is low in the cycle after an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_va | input | 64 | Virtual address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mode | input | 2 | Privilege mode, 0 = most privileged |
| req_pte_load | input | 1 | Request is a page-table-entry load |
| req_no_fault | input | 1 | Request must not capture fault state |
| req_wr_hint | input | 1 | Request is a write hint |
| req_misspec | input | 1 | Request is on a misspeculated path |
| pt_base | input | 64 | Page-table base used for the formatted address |
| ent_hit | input | 1 | Lookup hit |
| ent_rd_en | input | 4 | Read enable for each mode |
| ent_wr_en | input | 4 | Write enable for each mode |
| ent_fault_rd | input | 1 | Entry fault-on-read bit |
| ent_fault_wr | input | 1 | Entry fault-on-write bit |
| rsp_valid | output | 1 | Outcome valid |
| rsp_class | output | 3 | 0 none, 1 access, 2 protection, 3 miss, 4 table miss |
| rsp_status | output | 6 | Status word of the outcome |
| rsp_addr | output | 64 | Effective address |
| flt_va | output | 64 | Captured faulting address |
| flt_status | output | 6 | Captured status word |
| flt_form | output | 64 | Captured formatted address |
| cnt_rd_miss | output | 8 | Read miss count |
| cnt_wr_miss | output | 8 | Write miss count |
| cnt_rd_acv | output | 8 | Read protection fault count |
| cnt_wr_acv | output | 8 | Write protection fault count |

## Verification
The assertions assume that every input is a known value whenever `req_valid` is high. They also assume `req_mode` names one of the four modes. The bench drives every field of every request from a fixed table, so no input is left floating. Entry fields are kept meaningful even where a higher-priority cause makes them irrelevant. Idle cycles and the long counter run also drive complete, legal requests.

// File: rtl/dxf_pkg.sv
package dxf_pkg;

  // Outcome classes; the encoding is visible on rsp_class.
  typedef enum logic [2:0] {
    FC_NONE    = 3'd0,
    FC_ACCESS  = 3'd1,
    FC_PROT    = 3'd2,
    FC_MISS    = 3'd3,
    FC_MISS_PT = 3'd4
  } dxf_class_e;

  // Status word layout.
  localparam int ST_W     = 6;
  localparam int ST_WR    = 0;
  localparam int ST_ACV   = 1;
  localparam int ST_FOR   = 2;
  localparam int ST_FOW   = 3;
  localparam int ST_BADVA = 4;
  localparam int ST_MISS  = 5;

  // Which check produced the outcome (one-hot, zero when none).
  localparam int EV_W     = 5;
  localparam int EV_BADVA = 0;
  localparam int EV_SUPER = 1;
  localparam int EV_MISS  = 2;
  localparam int EV_PERM  = 3;
  localparam int EV_FON   = 4;

endpackage

// File: rtl/dxf_check.sv
module dxf_check
  import dxf_pkg::*;
#(
  parameter int IMPL_W = 43,
  parameter int VA_W   = 64,
  parameter int MODE_N = 4,
  localparam int MODE_W = $clog2(MODE_N),
  localparam int HI_W   = VA_W - IMPL_W + 2
) (
  input  logic [HI_W-1:0]   va_hi_i,
  input  logic              wr_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              pt_i,
  input  logic              hit_i,
  input  logic [MODE_N-1:0] rd_en_i,
  input  logic [MODE_N-1:0] wr_en_i,
  input  logic              for_i,
  input  logic              fow_i,
  output dxf_class_e        cls_o,
  output logic [ST_W-1:0]   stat_o,
  output logic [EV_W-1:0]   ev_o
);

  // Sign-extension test on the bits above the implemented range.
  function automatic logic va_canon(input logic [HI_W-1:0] hi);
    logic [HI_W-2:0] ext;
    ext = hi[HI_W-1:1];
    return (ext == '0) || (&ext);
  endfunction

  // Top two implemented bits select the superpage window.
  function automatic logic va_super(input logic [HI_W-1:0] hi);
    return hi[1:0] == 2'b10;
  endfunction

  logic bad_va, super_hit, priv, rd_ok, wr_ok;

  always_comb begin
    bad_va    = !va_canon(va_hi_i);
    super_hit = va_super(va_hi_i);
    priv      = (mode_i == '0);
    rd_ok     = rd_en_i[mode_i];
    wr_ok     = wr_en_i[mode_i];
    cls_o     = FC_NONE;
    stat_o    = '0;
    ev_o      = '0;
    if (bad_va) begin
      ev_o[EV_BADVA] = 1'b1;
      cls_o          = FC_PROT;
      stat_o[ST_WR]    = wr_i;
      stat_o[ST_ACV]   = 1'b1;
      stat_o[ST_BADVA] = 1'b1;
    end else if (super_hit) begin
      if (!priv) begin
        ev_o[EV_SUPER] = 1'b1;
        cls_o          = FC_ACCESS;
        stat_o[ST_WR]  = wr_i;
        stat_o[ST_ACV] = 1'b1;
      end
    end else if (!hit_i) begin
      ev_o[EV_MISS]   = 1'b1;
      cls_o           = pt_i ? FC_MISS_PT : FC_MISS;
      stat_o[ST_WR]   = wr_i;
      stat_o[ST_MISS] = 1'b1;
    end else if (wr_i) begin
      if (!wr_ok) begin
        ev_o[EV_PERM]  = 1'b1;
        cls_o          = FC_PROT;
        stat_o[ST_WR]  = 1'b1;
        stat_o[ST_ACV] = 1'b1;
        stat_o[ST_FOW] = fow_i;
      end else if (fow_i) begin
        ev_o[EV_FON]   = 1'b1;
        cls_o          = FC_PROT;
        stat_o[ST_WR]  = 1'b1;
        stat_o[ST_FOW] = 1'b1;
      end
    end else begin
      if (!rd_ok) begin
        ev_o[EV_PERM]  = 1'b1;
        cls_o          = FC_ACCESS;
        stat_o[ST_ACV] = 1'b1;
        stat_o[ST_FOR] = for_i;
      end else if (for_i) begin
        ev_o[EV_FON]   = 1'b1;
        cls_o          = FC_PROT;
        stat_o[ST_FOR] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dxf_latch.sv
module dxf_latch
  import dxf_pkg::*;
#(
  parameter int VA_W    = 64,
  parameter int PAGE_SH = 13,
  parameter int PTE_SH  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_i,
  input  logic [VA_W-1:0] va_i,
  input  logic [ST_W-1:0] stat_i,
  input  logic [VA_W-1:0] base_i,
  output logic [VA_W-1:0] fva_o,
  output logic [ST_W-1:0] fstat_o,
  output logic [VA_W-1:0] fform_o
);

  // Page-table entry address for the faulting page.
  function automatic logic [VA_W-1:0] fmt_addr(input logic [VA_W-1:0] base,
                                               input logic [VA_W-1:0] v);
    return base | ((v >> PAGE_SH) << PTE_SH);
  endfunction

  logic [VA_W-1:0] fva_q, fform_q;
  logic [ST_W-1:0] fstat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fva_q   <= '0;
      fstat_q <= '0;
      fform_q <= '0;
    end else if (take_i) begin
      fva_q   <= va_i;
      fstat_q <= stat_i;
      fform_q <= fmt_addr(base_i, va_i);
    end
  end

  assign fva_o   = fva_q;
  assign fstat_o = fstat_q;
  assign fform_o = fform_q;

  // R10
  hold_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_i |=> ($stable(fva_q) && $stable(fstat_q) && $stable(fform_q)));

  // R10
  load_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> (fva_q == $past(va_i) && fstat_q == $past(stat_i)));

endmodule

// File: rtl/dxf_sat_ctr.sv
module dxf_sat_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (inc_i && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R13
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == TOP) |=> (cnt_q == TOP));

  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_i |=> $stable(cnt_q));

endmodule

// File: rtl/dxf_unit.sv
module dxf_unit
  import dxf_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter int IMPL_W     = 43,
  parameter int MODE_N     = 4,
  parameter int PAGE_SH    = 13,
  parameter int HINT_BYTES = 64,
  parameter int CNT_W      = 8,
  localparam int MODE_W   = $clog2(MODE_N),
  localparam int ALIGN_SH = $clog2(HINT_BYTES),
  localparam int HI_W     = VA_W - IMPL_W + 2,
  localparam int N_CNT    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_va,
  input  logic              req_write,
  input  logic [MODE_W-1:0] req_mode,
  input  logic              req_pte_load,
  input  logic              req_no_fault,
  input  logic              req_wr_hint,
  input  logic              req_misspec,
  input  logic [VA_W-1:0]   pt_base,
  input  logic              ent_hit,
  input  logic [MODE_N-1:0] ent_rd_en,
  input  logic [MODE_N-1:0] ent_wr_en,
  input  logic              ent_fault_rd,
  input  logic              ent_fault_wr,
  output logic              rsp_valid,
  output logic [2:0]        rsp_class,
  output logic [ST_W-1:0]   rsp_status,
  output logic [VA_W-1:0]   rsp_addr,
  output logic [VA_W-1:0]   flt_va,
  output logic [ST_W-1:0]   flt_status,
  output logic [VA_W-1:0]   flt_form,
  output logic [CNT_W-1:0]  cnt_rd_miss,
  output logic [CNT_W-1:0]  cnt_wr_miss,
  output logic [CNT_W-1:0]  cnt_rd_acv,
  output logic [CNT_W-1:0]  cnt_wr_acv
);

  // Effective address: write hints round down to their line.
  function automatic logic [VA_W-1:0] line_align(input logic [VA_W-1:0] v);
    return {v[VA_W-1:ALIGN_SH], {ALIGN_SH{1'b0}}};
  endfunction

  logic [VA_W-1:0] eff_va;
  logic            eff_wr, eff_nf;
  dxf_class_e      chk_cls;
  logic [ST_W-1:0] chk_stat;
  logic [EV_W-1:0] chk_ev;
  logic            is_fault, is_miss, take;
  logic [N_CNT-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_q [N_CNT];

  assign eff_va = req_wr_hint ? line_align(req_va) : req_va;
  assign eff_wr = req_write | req_wr_hint;
  assign eff_nf = req_no_fault | req_wr_hint;

  dxf_check #(
    .IMPL_W (IMPL_W),
    .VA_W   (VA_W),
    .MODE_N (MODE_N)
  ) u_check (
    .va_hi_i (eff_va[VA_W-1:IMPL_W-2]),
    .wr_i    (eff_wr),
    .mode_i  (req_mode),
    .pt_i    (req_pte_load),
    .hit_i   (ent_hit),
    .rd_en_i (ent_rd_en),
    .wr_en_i (ent_wr_en),
    .for_i   (ent_fault_rd),
    .fow_i   (ent_fault_wr),
    .cls_o   (chk_cls),
    .stat_o  (chk_stat),
    .ev_o    (chk_ev)
  );

  assign is_fault = req_valid && (chk_cls != FC_NONE);
  assign is_miss  = (chk_cls == FC_MISS) || (chk_cls == FC_MISS_PT);
  assign take     = is_fault && !req_pte_load && !eff_nf && !req_misspec;

  // Counter order: read miss, write miss, read protection, write protection.
  assign cnt_inc[0] = is_fault &&  is_miss && !eff_wr;
  assign cnt_inc[1] = is_fault &&  is_miss &&  eff_wr;
  assign cnt_inc[2] = is_fault && !is_miss && !eff_wr;
  assign cnt_inc[3] = is_fault && !is_miss &&  eff_wr;

  dxf_latch #(
    .VA_W    (VA_W),
    .PAGE_SH (PAGE_SH)
  ) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .take_i  (take),
    .va_i    (eff_va),
    .stat_i  (chk_stat),
    .base_i  (pt_base),
    .fva_o   (flt_va),
    .fstat_o (flt_status),
    .fform_o (flt_form)
  );

  for (genvar k = 0; k < N_CNT; k++) begin : g_ctr
    dxf_sat_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc_i (cnt_inc[k]),
      .cnt_o (cnt_q[k])
    );
  end

  assign cnt_rd_miss = cnt_q[0];
  assign cnt_wr_miss = cnt_q[1];
  assign cnt_rd_acv  = cnt_q[2];
  assign cnt_wr_acv  = cnt_q[3];

  // Response stage.
  logic            vld_q, hint_q;
  dxf_class_e      cls_q;
  logic [ST_W-1:0] stat_q;
  logic [VA_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      hint_q <= 1'b0;
      cls_q  <= FC_NONE;
      stat_q <= '0;
      addr_q <= '0;
    end else begin
      vld_q  <= req_valid;
      hint_q <= req_valid && req_wr_hint;
      if (req_valid) begin
        cls_q  <= chk_cls;
        stat_q <= chk_stat;
        addr_q <= eff_va;
      end
    end
  end

  assign rsp_valid  = vld_q;
  assign rsp_class  = cls_q;
  assign rsp_status = stat_q;
  assign rsp_addr   = addr_q;

  // R9
  one_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $onehot0(chk_ev));

  // R14
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));

  // R12
  hint_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && hint_q) |-> (rsp_addr[ALIGN_SH-1:0] == '0));

  // R2
  badva_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status[ST_BADVA]) |-> (rsp_class == 3'(FC_PROT)));

  // R13
  one_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cnt_inc) <= 1);

  // R10
  hint_nolatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_wr_hint) |=> $stable(flt_va));

endmodule

// File: tb/sim_dxf_unit.sv
`timescale 1ns/1ps
module sim_dxf_unit;

  localparam logic [63:0] VA_A  = 64'h0000_0000_1234_6000;
  localparam logic [63:0] VA_B  = 64'h0001_0000_0000_0000;
  localparam logic [63:0] VA_S  = 64'hFFFF_FC00_0000_2000;
  localparam logic [63:0] VA_C  = 64'h0000_0007_8000_A000;
  localparam logic [63:0] PTB   = 64'h0000_0002_0000_0000;

  typedef struct packed {
    logic [63:0] va;
    logic        wr;
    logic [1:0]  md;
    logic        pt;
    logic        nf;
    logic        hn;
    logic        ms;
    logic        hit;
    logic [3:0]  re;
    logic [3:0]  we;
    logic        fr;
    logic        fw;
    logic [2:0]  cls;
    logic [5:0]  st;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 21;
  // va, wr, md, pt, nf, hn, ms, hit, re, we, fr, fw, cls, st, requirement
  localparam vec_t VT [NV] = '{
    '{VA_A, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'hF, 4'hF, 1'b0, 1'b0, 3'd0, 6'h00, 8'd9},  // R9 clean hit
    '{VA_B, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'hF, 4'hF, 1'b0, 1'b0, 3'd2, 6'h12, 8'd2},  // R2 read
    '{VA_B, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'hF, 4'hF, 1'b0, 1'b0, 3'd2, 6'h13, 8'd2},  // R2 write beats miss
    '{VA_S, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'hF, 4'hF, 1'b0, 1'b0, 3'd1, 6'h02, 8'd3},  // R3
    '{VA_S, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'hF, 4'hF, 1'b0, 1'b0, 3'd1, 6'h03, 8'd3},  // R3
    '{VA_S, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 4'h0, 1'b1, 1'b1, 3'd0, 6'h00, 8'd3},  // R3 kernel
    '{VA_A, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'hF, 4'hF, 1'b0, 1'b0, 3'd3, 6'h20, 8'd4},  // R4
    '{VA_A, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'hF, 4'hF, 1'b0, 1'b0, 3'd4, 6'h21, 8'd4},  // R4 table miss
    '{VA_A, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'hF, 4'hB, 1'b0, 1'b1, 3'd2, 6'h0B, 8'd5},  // R5
    '{VA_A, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'hF, 4'hB, 1'b0, 1'b0, 3'd2, 6'h03, 8'd5},  // R5
    '{VA_A, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'hF, 4'h2, 1'b0, 1'b1, 3'd2, 6'h09, 8'd6},  // R6
    '{VA_A, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'h7, 4'hF, 1'b1, 1'b0, 3'd1, 6'h06, 8'd7},  // R7
    '{VA_A, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'h7, 4'hF, 1'b0, 1'b0, 3'd1, 6'h02, 8'd7},  // R7
    '{VA_A, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'h1, 4'hF, 1'b1, 1'b1, 3'd2, 6'h04, 8'd8},  // R8
    '{VA_A, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'hF, 4'h1, 1'b1, 1'b0, 3'd0, 6'h00, 8'd8},  // R8 write ignores fr
    '{VA_A, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 4'h0, 1'b1, 1'b1, 3'd3, 6'h20, 8'd9},  // R9 miss before perm
    '{VA_B, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 4'hF, 1'b0, 1'b0, 3'd2, 6'h12, 8'd10}, // R10 no-fault
    '{VA_A, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'hF, 4'hF, 1'b0, 1'b0, 3'd4, 6'h20, 8'd10}, // R10 table load
    '{VA_B, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'hF, 4'hF, 1'b0, 1'b0, 3'd2, 6'h13, 8'd10}, // R10 misspec
    '{VA_A | 64'h2F, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'hF, 4'hF, 1'b0, 1'b0, 3'd3, 6'h21, 8'd12}, // R12
    '{VA_C, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'h3, 4'hF, 1'b0, 1'b0, 3'd1, 6'h02, 8'd11}  // R11
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] req_va = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_mode = '0;
  logic        req_pte_load = 1'b0, req_no_fault = 1'b0, req_wr_hint = 1'b0, req_misspec = 1'b0;
  logic [63:0] pt_base = PTB;
  logic        ent_hit = 1'b0;
  logic [3:0]  ent_rd_en = '0, ent_wr_en = '0;
  logic        ent_fault_rd = 1'b0, ent_fault_wr = 1'b0;
  logic        rsp_valid;
  logic [2:0]  rsp_class;
  logic [5:0]  rsp_status, flt_status;
  logic [63:0] rsp_addr, flt_va, flt_form;
  logic [7:0]  cnt_rd_miss, cnt_wr_miss, cnt_rd_acv, cnt_wr_acv;

  always #4 clk = ~clk;

  dxf_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_write(req_write), .req_mode(req_mode), .req_pte_load(req_pte_load),
    .req_no_fault(req_no_fault), .req_wr_hint(req_wr_hint), .req_misspec(req_misspec),
    .pt_base(pt_base), .ent_hit(ent_hit), .ent_rd_en(ent_rd_en), .ent_wr_en(ent_wr_en),
    .ent_fault_rd(ent_fault_rd), .ent_fault_wr(ent_fault_wr),
    .rsp_valid(rsp_valid), .rsp_class(rsp_class), .rsp_status(rsp_status),
    .rsp_addr(rsp_addr), .flt_va(flt_va), .flt_status(flt_status), .flt_form(flt_form),
    .cnt_rd_miss(cnt_rd_miss), .cnt_wr_miss(cnt_wr_miss),
    .cnt_rd_acv(cnt_rd_acv), .cnt_wr_acv(cnt_wr_acv)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [63:0] m_va = '0, m_form = '0;
  logic [5:0]  m_st = '0;
  int m_rm = 0, m_wm = 0, m_ra = 0, m_wa = 0;

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  function automatic int sat(input int v);
    return (v > 255) ? 255 : v;
  endfunction

  task automatic drive(input vec_t v);
    req_valid = 1'b1; req_va = v.va; req_write = v.wr; req_mode = v.md;
    req_pte_load = v.pt; req_no_fault = v.nf; req_wr_hint = v.hn; req_misspec = v.ms;
    ent_hit = v.hit; ent_rd_en = v.re; ent_wr_en = v.we;
    ent_fault_rd = v.fr; ent_fault_wr = v.fw;
  endtask

  // Bench-side model of the captured registers and the counters.
  task automatic model(input vec_t v);
    logic [63:0] ea;
    ea = v.hn ? (v.va & ~64'd63) : v.va;
    if (v.cls != 3'd0) begin
      if (!v.pt && !v.nf && !v.hn && !v.ms) begin
        m_va = ea; m_st = v.st;
        m_form = PTB | ((ea >> 10) & ~64'h7);
      end
      if (v.cls >= 3'd3) begin
        if (v.wr || v.hn) m_wm++; else m_rm++;
      end else begin
        if (v.wr || v.hn) m_wa++; else m_ra++;
      end
    end
  endtask

  task automatic check_counters(input string rq);
    chk(rq, "cnt_rd_miss", 64'(cnt_rd_miss), 64'(sat(m_rm)));
    chk(rq, "cnt_wr_miss", 64'(cnt_wr_miss), 64'(sat(m_wm)));
    chk(rq, "cnt_rd_acv",  64'(cnt_rd_acv),  64'(sat(m_ra)));
    chk(rq, "cnt_wr_acv",  64'(cnt_wr_acv),  64'(sat(m_wa)));
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 state under reset
    chk("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1", "flt_va", flt_va, 64'd0);
    chk("R1", "flt_form", flt_form, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 first cycle after release
    chk("R1", "rsp_class", 64'(rsp_class), 64'd0);
    chk("R1", "flt_status", 64'(flt_status), 64'd0);
    check_counters("R1");

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", VT[i].tag);
      drive(VT[i]);
      model(VT[i]);
      @(negedge clk);
      chk(rq, "rsp_valid (R14)", 64'(rsp_valid), 64'd1);
      chk(rq, "rsp_class", 64'(rsp_class), 64'(VT[i].cls));
      chk(rq, "rsp_status", 64'(rsp_status), 64'(VT[i].st));
      chk(rq, "rsp_addr", rsp_addr, VT[i].hn ? (VT[i].va & ~64'd63) : VT[i].va);
      chk(rq, "flt_va (R10)", flt_va, m_va);
      chk(rq, "flt_status (R10)", 64'(flt_status), 64'(m_st));
      chk(rq, "flt_form (R11)", flt_form, m_form);
    end
    check_counters("R13");

    // R14 idle cycle: no response, fault registers untouched
    req_valid = 1'b0;
    req_va = VA_B;
    @(negedge clk);
    chk("R14", "rsp_valid idle", 64'(rsp_valid), 64'd0);
    chk("R10", "flt_va idle", flt_va, m_va);

    // R13 saturation: long run of misspeculated read misses
    drive(VT[6]);
    req_misspec = 1'b1;
    for (int k = 0; k < 300; k++) begin
      model(VT[18]);           // keep latch model untouched; fix counters below
      m_wa--;                  // VT[18] is a write protection fault; undo
      m_rm++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    @(negedge clk);
    check_counters("R13");
    chk("R13", "cnt_rd_miss saturated", 64'(cnt_rd_miss), 64'd255);
    chk("R10", "flt_va after misspec run", flt_va, m_va);

    done = 1;
    summary();
    $finish;
  end

endmodule